// File: doc/BRIEF.md
# Prioritized Masked Interrupt Selector

The selector holds one pending bit for each of seven interrupt sources. Every cycle it chooses the one pending request with the highest priority that its masking rule allows. The sources, from highest to lowest priority, are: poll, startup, system-management, non-maskable, machine-check, hardware IRQ and virtual IRQ. Each source has its own masking condition. A global gate controls the five lowest sources, while poll and startup bypass that gate.

The choice is combinational and appears as a one-hot grant, a has-work flag and, where it applies, a vector number. The surrounding core pulses `service` to accept the granted source. On the next edge the selector clears the serviced pending bit or bits and updates its non-maskable blocking flag. The core itself fetches vectors from the interrupt controller and performs any mode entry. All control pins are plain levels or strobes, with no handshake.

Top module: `intsel_top`

## Requirements
- R1: Bit 0 (poll) is granted whenever it is pending, regardless of every flag.
- R2: Bit 1 (startup) ranks second and is granted while pending with `gif` low, if poll is not pending.
- R3: While `gif` is low, grant bits 2 to 6 stay zero.
- R4: With `gif` high, the priority order is bit 2 > 3 > 4 > 5 > 6. Bit 2 (system-management) is masked while `in_smm` is high.
- R5: Bit 3 (non-maskable) is masked while `nmi_blocked` is high. Servicing it sets `nmi_blocked` on the next edge. `nmi_unblock` clears the flag, and a service that sets the flag wins over `nmi_unblock` in the same cycle.
- R6: `vec_valid` is high for grants of bits 3, 4, 5 and 6. `vec` is 2 for bit 3, 18 for bit 4, and `ext_vector` for bits 5 and 6. Otherwise `vec` is 0.
- R7: Bit 5 (hardware IRQ) is gated by `host_if` when `vmode` is high. When `vmode` is low it needs `ie` high and `inhibit` low.
- R8: Bit 6 (virtual IRQ) needs `ie` high and `inhibit` low.
- R9: A service strobe clears only the granted bit. Servicing bit 5 also clears bit 6, and only one source is serviced per strobe.
- R10: `grant` is zero or one-hot, and `has_work` is high exactly when `grant` is nonzero.
- R11: A `req_set` bit and a clear of the same bit in one cycle leave that bit pending.
- R12: After reset, `pending`, `grant` and `nmi_blocked` are zero.
- R13: A service strobe while nothing is granted changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 7 | Per-source request pulses that set pending bits |
| gif | input | 1 | Global gate for sources 2 to 6 |
| in_smm | input | 1 | Core already in system-management mode |
| vmode | input | 1 | Virtual-interrupt mode active |
| host_if | input | 1 | Host interrupt flag, used in virtual mode |
| ie | input | 1 | Interrupt-enable flag |
| inhibit | input | 1 | One-instruction interrupt shadow |
| nmi_unblock | input | 1 | Clears the non-maskable block flag |
| ext_vector | input | VEC_W | Vector supplied by the interrupt controller |
| service | input | 1 | Strobe that accepts the current grant |
| grant | output | 7 | One-hot selected source |
| has_work | output | 1 | Some source is selectable |
| vec_valid | output | 1 | `vec` is meaningful |
| vec | output | VEC_W | Vector of the granted source |
| pending | output | 7 | Pending request bits |
| nmi_blocked | output | 1 | Non-maskable block flag |

## Verification
If a pending bit is lost or stuck, `pending` shows it on the cycle after the faulty edge. `grant` then shows a different winner at once, because selection has no pipeline. A wrong blocking flag appears the cycle after the non-maskable service: a second non-maskable request then wins or loses the grant, and `nmi_blocked` shows the wrong value. The bench models the pending bits and the flag itself and compares every output in every cycle, so it reports a divergence within one cycle.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
  localparam int NSRC     = 7;
  localparam int SRC_POLL = 0;
  localparam int SRC_SIPI = 1;
  localparam int SRC_SMI  = 2;
  localparam int SRC_NMI  = 3;
  localparam int SRC_MCE  = 4;
  localparam int SRC_HW   = 5;
  localparam int SRC_VIRQ = 6;
  localparam int VEC_NMI  = 2;
  localparam int VEC_MCE  = 18;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/intsel_pending.sv
module intsel_pending #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/intsel_mask.sv
module intsel_mask
  import intsel_pkg::*;
(
  input  src_vec_t pend_i,
  input  logic     gif_i,
  input  logic     in_smm_i,
  input  logic     nmi_blk_i,
  input  logic     vmode_i,
  input  logic     host_if_i,
  input  logic     ie_i,
  input  logic     inhibit_i,
  output src_vec_t elig_o
);
  logic irq_open;
  always_comb begin
    irq_open          = ie_i && !inhibit_i;
    elig_o            = '0;
    elig_o[SRC_POLL]  = pend_i[SRC_POLL];
    elig_o[SRC_SIPI]  = pend_i[SRC_SIPI];
    if (gif_i) begin
      elig_o[SRC_SMI]  = pend_i[SRC_SMI] && !in_smm_i;
      elig_o[SRC_NMI]  = pend_i[SRC_NMI] && !nmi_blk_i;
      elig_o[SRC_MCE]  = pend_i[SRC_MCE];
      elig_o[SRC_HW]   = pend_i[SRC_HW] && (vmode_i ? host_if_i : irq_open);
      elig_o[SRC_VIRQ] = pend_i[SRC_VIRQ] && irq_open;
    end
  end
endmodule

// File: rtl/intsel_prio.sv
module intsel_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | elig_i[i];
    assign grant_o[i] = elig_i[i] & ~seen[i];
  end
endmodule

// File: rtl/intsel_top.sv
module intsel_top
  import intsel_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_set,
  input  logic             gif,
  input  logic             in_smm,
  input  logic             vmode,
  input  logic             host_if,
  input  logic             ie,
  input  logic             inhibit,
  input  logic             nmi_unblock,
  input  logic [VEC_W-1:0] ext_vector,
  input  logic             service,
  output logic [NSRC-1:0]  grant,
  output logic             has_work,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec,
  output logic [NSRC-1:0]  pending,
  output logic             nmi_blocked
);
  src_vec_t elig, clr;

  intsel_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(clr), .pend_o(pending)
  );

  intsel_mask u_mask (
    .pend_i(pending), .gif_i(gif), .in_smm_i(in_smm), .nmi_blk_i(nmi_blocked),
    .vmode_i(vmode), .host_if_i(host_if), .ie_i(ie), .inhibit_i(inhibit),
    .elig_o(elig)
  );

  intsel_prio #(.N(NSRC)) u_prio (.elig_i(elig), .grant_o(grant));

  assign has_work = |elig;

  always_comb begin
    clr = '0;
    if (service) begin
      clr = grant;
      if (grant[SRC_HW]) clr[SRC_VIRQ] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        nmi_blocked <= 1'b0;
    else if (service && grant[SRC_NMI]) nmi_blocked <= 1'b1;
    else if (nmi_unblock)              nmi_blocked <= 1'b0;
  end

  always_comb begin
    vec_valid = 1'b1;
    vec       = '0;
    if (grant[SRC_NMI])                       vec = VEC_W'(VEC_NMI);
    else if (grant[SRC_MCE])                  vec = VEC_W'(VEC_MCE);
    else if (grant[SRC_HW] || grant[SRC_VIRQ]) vec = ext_vector;
    else                                      vec_valid = 1'b0;
  end
endmodule

// File: rtl/intsel_chk.sv
module intsel_chk
  import intsel_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            gif,
  input logic            service,
  input logic [NSRC-1:0] req_set,
  input logic [NSRC-1:0] grant,
  input logic            has_work,
  input logic [NSRC-1:0] pending,
  input logic            nmi_blocked
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R10
  work_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_work == (grant != '0));
  // R3
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gif |-> (grant[NSRC-1:SRC_SMI] == '0));
  // R1
  poll_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending[SRC_POLL] |-> grant[SRC_POLL]);
  // R5
  nmi_block_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (service && grant[SRC_NMI]) |=> nmi_blocked);
  // R9
  hw_clears_virq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (service && grant[SRC_HW] && !req_set[SRC_HW] && !req_set[SRC_VIRQ])
      |=> (!pending[SRC_HW] && !pending[SRC_VIRQ]));
endmodule

bind intsel_top intsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gif(gif), .service(service), .req_set(req_set),
  .grant(grant), .has_work(has_work), .pending(pending), .nmi_blocked(nmi_blocked)
);

// File: tb/intsel_top_test.sv
`timescale 1ns/1ps
module intsel_top_test;
  localparam int VW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] req_set = '0;
  logic gif = 0, in_smm = 0, vmode = 0, host_if = 0, ie = 0, inhibit = 0;
  logic nmi_unblock = 0, service = 0;
  logic [VW-1:0] ext_vector = '0;
  logic [6:0] grant, pending;
  logic has_work, vec_valid, nmi_blocked;
  logic [VW-1:0] vec;
  int checks = 0, fails = 0;
  logic [6:0] m_pend = '0;
  logic m_blk = 1'b0;

  always #4 clk = ~clk;

  intsel_top #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .gif(gif), .in_smm(in_smm),
    .vmode(vmode), .host_if(host_if), .ie(ie), .inhibit(inhibit),
    .nmi_unblock(nmi_unblock), .ext_vector(ext_vector), .service(service),
    .grant(grant), .has_work(has_work), .vec_valid(vec_valid), .vec(vec),
    .pending(pending), .nmi_blocked(nmi_blocked)
  );

  function automatic logic [6:0] exp_grant();
    logic [6:0] e;
    logic open_irq;
    open_irq = ie && !inhibit;
    e = '0;
    e[0] = m_pend[0];
    e[1] = m_pend[1];
    if (gif) begin
      e[2] = m_pend[2] && !in_smm;
      e[3] = m_pend[3] && !m_blk;
      e[4] = m_pend[4];
      e[5] = m_pend[5] && (vmode ? host_if : open_irq);
      e[6] = m_pend[6] && open_irq;
    end
    for (int i = 0; i < 7; i++) if (e[i]) return 7'(1 << i);
    return '0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [6:0] s, logic g, logic sm, logic vm,
                      logic hf, logic e, logic inh, logic ub, logic srv,
                      logic [VW-1:0] ev);
    logic [6:0] eg, clr;
    logic [VW-1:0] ev_exp;
    @(negedge clk);
    req_set = s; gif = g; in_smm = sm; vmode = vm; host_if = hf; ie = e;
    inhibit = inh; nmi_unblock = ub; service = srv; ext_vector = ev;
    #1;
    eg = exp_grant();
    ev_exp = eg[3] ? VW'(2) : eg[4] ? VW'(18) : (eg[5] || eg[6]) ? ev : '0;
    check(tag, "pending", 32'(pending), 32'(m_pend));
    check(tag, "nmi_blocked", 32'(nmi_blocked), 32'(m_blk));
    check(tag, "grant", 32'(grant), 32'(eg));
    check(tag, "has_work", 32'(has_work), 32'(eg != 0));
    check(tag, "vec_valid", 32'(vec_valid), 32'(|eg[6:3]));
    check(tag, "vec", 32'(vec), 32'(ev_exp));
    clr = '0;
    if (srv) begin
      clr = eg;
      if (eg[5]) clr[6] = 1'b1;
    end
    m_pend = (m_pend & ~clr) | s;
    if (srv && eg[3]) m_blk = 1'b1;
    else if (ub)      m_blk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED);
    #3;
    // R12 values held in reset
    check("R12", "pending_rst", 32'(pending), 0);
    check("R12", "grant_rst", 32'(grant), 0);
    check("R12", "blk_rst", 32'(nmi_blocked), 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    step("R12", 7'h00, 0,0,0,0,0,0,0,0, 8'h00);
    step("R3",  7'h7F, 0,0,0,0,0,0,0,0, 8'h00);
    step("R1",  7'h00, 0,0,0,0,0,0,0,1, 8'h00);
    step("R2",  7'h00, 0,0,0,0,0,0,0,1, 8'h00);
    step("R3",  7'h00, 0,0,0,1,1,0,0,0, 8'h00);
    step("R4",  7'h00, 1,1,0,0,0,0,0,1, 8'h00);
    step("R5",  7'h00, 1,1,0,0,0,0,0,0, 8'h00);
    step("R4",  7'h00, 1,0,0,0,0,0,0,1, 8'h00);
    step("R6",  7'h00, 1,0,0,0,0,0,0,1, 8'h00);
    step("R8",  7'h00, 1,0,1,0,1,0,0,0, 8'h41);
    step("R7",  7'h00, 1,0,1,1,0,0,0,1, 8'h42);
    step("R9",  7'h00, 1,0,0,0,1,0,0,0, 8'h00);
    step("R5",  7'h08, 1,0,0,0,0,0,1,0, 8'h00);
    step("R5",  7'h00, 1,0,0,0,0,0,0,1, 8'h00);
    step("R11", 7'h18, 1,0,0,0,0,0,1,0, 8'h00);
    step("R11", 7'h10, 1,0,0,0,0,0,0,1, 8'h00);
    step("R13", 7'h00, 0,0,0,0,0,0,0,1, 8'h00);
    step("R13", 7'h00, 0,0,0,0,0,0,0,0, 8'h00);
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] s;
      s = 7'($urandom) & 7'($urandom) & 7'($urandom);
      step("R10", s, ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
           1'($urandom), 8'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule